// File: doc/BRIEF.md
# Channel-List Scan Sequencer with Sample FIFO

This block drives an analog front end from a programmable list of up to sixteen entries. Each entry selects a multiplexer channel, a gain code and a unipolar/bipolar flag. A conversion pulse from an external timer starts one conversion. The sequencer presents the current entry to the front end and waits for the converter's done strobe. It then pushes the returned sample into a FIFO and advances to the next entry.

Software uses a small register interface. It writes list entries, each of which carries its own index. It sets the scan window (first and last index) and the gate bits in a control word, and sets scan and interrupt options in a mode word. It reads samples and status back. When the last entry of the window has converted, the block latches end-of-scan, raises an interrupt if that is enabled, and wraps to the first index so the next scan needs no software action. Reading one dedicated address empties the sample FIFO.

Register addresses: 0 reads the FIFO and writes the control word; 1 reads status; 2 writes a list entry; 3 writes and reads the mode word; 4 is a read that flushes the FIFO and returns zero.

Top module: `scan_seq`

## Requirements
- R1: A list write (address 2) stores channel from bits 3:0, gain from bits 5:4 and the unipolar flag from bit 7 at the index in bits 11:8. When a conversion is accepted, that entry appears on fe_chan, fe_gain and fe_unipolar, and conv_start pulses in the cycle after the accepting edge.
- R2: With scan enabled (mode bit 3), each completed conversion advances the position by one from the start index (control bits 3:0). After the entry at the last index (control bits 11:8) completes, status bit 13 latches and the position returns to the start index.
- R3: With scan disabled, every conversion uses the entry at the start index and end-of-scan never latches.
- R4: A conversion pulse is accepted only while gate 0 (control bit 12) is set, no conversion is in flight and, if external start (control bit 15) is set, ext_trig has been seen high since the last control write. Ignored pulses push nothing.
- R5: Any control write reloads the position with the new start index and aborts a conversion in flight. Writing zero drives all gates low, disables external start and stops acceptance.
- R6: Samples leave the FIFO in arrival order. Status bit 1 shows empty and bit 2 shows full. A sample that completes while the FIFO is full is dropped, and full stays set.
- R7: A FIFO read while the FIFO is empty returns the last value read and leaves the FIFO empty, so later samples are read correctly.
- R8: A read of address 4 empties the FIFO.
- R9: Status bit 15 reads 1 while a conversion is in flight and 0 once its sample is available.
- R10: irq is high when end-of-scan is latched and mode bit 1 is set, or when an end-of-conversion event is latched and mode bit 0 is set. A status read clears both latches.
- R11: Status bits 11:8 show the di levels and bits 7:4 show the REV_CODE parameter. Bits 14, 12, 3 and 0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects at the clock edge) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| conv_pulse | input | 1 | Conversion request from the pacing timer |
| ext_trig | input | 1 | External start trigger level |
| adc_done | input | 1 | Converter done strobe |
| adc_data | input | 16 | Converted sample |
| di | input | 4 | Digital input levels |
| conv_start | output | 1 | One-cycle conversion start to the converter |
| fe_chan | output | 4 | Multiplexer channel of the current entry |
| fe_gain | output | 2 | Gain code of the current entry |
| fe_unipolar | output | 1 | Unipolar flag of the current entry |
| gates | output | 3 | Timer gate enables from control bits 14:12 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a completed conversion that meets a full FIFO while end-of-scan wraps the position. The stimulus keeps converting past the FIFO depth with scan enabled and a window of three entries, so overflow drops happen at every list position. Random list contents and samples are checked against a bench model of position, FIFO and latches. Directed steps cover reads of an empty FIFO, flushes, external-start arming and a zero control write.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef struct packed {
        logic       uni;
        logic [1:0] gain;
        logic [3:0] chan;
    } entry_t;

    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_LIST  = 3'd2;
    localparam logic [2:0] A_MODE  = 3'd3;
    localparam logic [2:0] A_FLUSH = 3'd4;
endpackage

// File: rtl/scan_list.sv
module scan_list
    import scan_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  entry_t        wentry,
    input  logic [IW-1:0] ridx,
    output entry_t        rentry
);
    entry_t mem_d [DEPTH];
    entry_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[widx] = wentry;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rentry = mem_q[ridx];

    assert_list_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(widx)] == $past(wentry));
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [DW-1:0] last;
    } fst_t;

    fst_t          s_d, s_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = empty ? s_q.last : mem_q[s_q.rp];

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                mem_d[s_q.wp] = din;
                s_d.wp = s_q.wp + 1'b1;
            end
            if (do_pop) begin
                s_d.last = mem_q[s_q.rp];
                s_d.rp   = s_q.rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(s_q.wp)));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (empty && $stable(s_q.rp)));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/scan_engine.sv
module scan_engine
    import scan_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_pulse,
    input  logic          run_ok,
    input  logic          scan_en,
    input  logic [IW-1:0] start_idx,
    input  logic [IW-1:0] last_idx,
    input  logic          restart,
    input  logic [IW-1:0] restart_idx,
    input  logic          adc_done,
    input  entry_t        entry,
    output logic [IW-1:0] pos,
    output entry_t        fe,
    output logic          conv_start,
    output logic          busy,
    output logic          push,
    output logic          eoc_evt,
    output logic          eos_evt
);
    typedef struct packed {
        logic [IW-1:0] pos;
        logic          busy;
        logic          start_p;
        entry_t        fe;
    } est_t;

    est_t s_d, s_q;
    logic accept, finish, at_last;

    assign accept  = conv_pulse && run_ok && !s_q.busy && !restart;
    assign finish  = adc_done && s_q.busy && !restart;
    assign at_last = (s_q.pos == last_idx);

    always_comb begin
        s_d = s_q;
        s_d.start_p = 1'b0;
        if (restart) begin
            s_d.pos  = restart_idx;
            s_d.busy = 1'b0;
        end else if (accept) begin
            s_d.busy    = 1'b1;
            s_d.start_p = 1'b1;
            s_d.fe      = entry;
        end else if (finish) begin
            s_d.busy = 1'b0;
            if (scan_en) s_d.pos = at_last ? start_idx : s_q.pos + 1'b1;
            else         s_d.pos = start_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos        = s_q.pos;
    assign fe         = s_q.fe;
    assign conv_start = s_q.start_p;
    assign busy       = s_q.busy;
    assign push       = finish;
    assign eoc_evt    = finish;
    assign eos_evt    = finish && scan_en && at_last;

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && scan_en && at_last) |=> (pos == $past(start_idx)));
    assert_fixed_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !scan_en) |=> (pos == $past(start_idx)));
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && conv_start));
    assert_no_start_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !restart && !adc_done) |=> !conv_start);
endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int         LIST_DEPTH = 16,
    parameter int         FIFO_DEPTH = 16,
    parameter logic [3:0] REV_CODE   = 4'hB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        conv_pulse,
    input  logic        ext_trig,
    input  logic        adc_done,
    input  logic [15:0] adc_data,
    input  logic [3:0]  di,
    output logic        conv_start,
    output logic [3:0]  fe_chan,
    output logic [1:0]  fe_gain,
    output logic        fe_unipolar,
    output logic [2:0]  gates,
    output logic        irq
);
    localparam int IW = $clog2(LIST_DEPTH);

    typedef struct packed {
        logic [15:0] ctrl;
        logic [7:0]  mode;
        logic        armed;
        logic        eos;
        logic        eoc;
    } tst_t;

    tst_t    s_d, s_q;
    entry_t  list_out, fe, wentry;
    logic [IW-1:0] pos;
    logic    ctrl_wr, list_wr, mode_wr, fifo_rd, stat_rd, flush_rd;
    logic    run_ok, busy, push, eoc_evt, eos_evt;
    logic [15:0] fifo_dout;
    logic    fifo_empty, fifo_full;

    assign ctrl_wr  = wr_en && addr == A_DATA;
    assign list_wr  = wr_en && addr == A_LIST;
    assign mode_wr  = wr_en && addr == A_MODE;
    assign fifo_rd  = rd_en && addr == A_DATA;
    assign stat_rd  = rd_en && addr == A_STAT;
    assign flush_rd = rd_en && addr == A_FLUSH;

    assign wentry = '{uni: wdata[7], gain: wdata[5:4], chan: wdata[3:0]};
    assign run_ok = s_q.ctrl[12] && (!s_q.ctrl[15] || s_q.armed);

    always_comb begin
        s_d = s_q;
        if (ctrl_wr) begin
            s_d.ctrl  = wdata;
            s_d.armed = 1'b0;
        end else if (s_q.ctrl[15] && ext_trig) begin
            s_d.armed = 1'b1;
        end
        if (mode_wr) s_d.mode = wdata[7:0];
        s_d.eos = eos_evt || (s_q.eos && !stat_rd);
        s_d.eoc = eoc_evt || (s_q.eoc && !stat_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    scan_list #(.DEPTH(LIST_DEPTH)) u_list (
        .clk(clk), .rst_n(rst_n),
        .we(list_wr), .widx(wdata[8 +: IW]), .wentry(wentry),
        .ridx(pos), .rentry(list_out)
    );

    scan_engine #(.DEPTH(LIST_DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .conv_pulse(conv_pulse), .run_ok(run_ok),
        .scan_en(s_q.mode[3]),
        .start_idx(s_q.ctrl[0 +: IW]), .last_idx(s_q.ctrl[8 +: IW]),
        .restart(ctrl_wr), .restart_idx(wdata[0 +: IW]),
        .adc_done(adc_done), .entry(list_out),
        .pos(pos), .fe(fe), .conv_start(conv_start), .busy(busy),
        .push(push), .eoc_evt(eoc_evt), .eos_evt(eos_evt)
    );

    sample_fifo #(.DW(16), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(adc_data), .pop(fifo_rd), .flush(flush_rd),
        .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
    );

    always_comb begin
        case (addr)
            A_DATA:  rdata = fifo_dout;
            A_STAT:  rdata = {busy, 1'b0, s_q.eos, 1'b0, di, REV_CODE,
                              1'b0, fifo_full, fifo_empty, 1'b0};
            A_MODE:  rdata = {8'h00, s_q.mode};
            default: rdata = 16'h0000;
        endcase
    end

    assign fe_chan     = fe.chan;
    assign fe_gain     = fe.gain;
    assign fe_unipolar = fe.uni;
    assign gates       = s_q.ctrl[14:12];
    assign irq         = (s_q.eos && s_q.mode[1]) || (s_q.eoc && s_q.mode[0]);

    assert_ctrl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata == 16'h0000) |=> (gates == 3'b000 && !busy));
    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !adc_done) |=> !irq);
    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ok && !wr_en) |=> !conv_start);
endmodule

// File: tb/sim_scan_seq.sv
module sim_scan_seq;
    localparam int FD = 16;
    localparam logic [3:0] REV = 4'hB;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [2:0] addr = 0;
    logic [15:0] wdata = 0, rdata, adc_data = 0;
    logic conv_pulse = 0, ext_trig = 0, adc_done = 0;
    logic [3:0] di = 4'hA;
    logic conv_start, fe_unipolar, irq;
    logic [3:0] fe_chan;
    logic [1:0] fe_gain;
    logic [2:0] gates;

    always #5 clk = ~clk;

    scan_seq u0 (.*);

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [6:0]  bl [16];
    logic [15:0] bq [$];
    logic [15:0] lastv = 0;
    int bpos = 0, bstart = 0, blast = 0;
    bit bscan = 0, bgate = 0, bext = 0, barmed = 0, beos = 0, beoc = 0;
    logic [7:0] bmode = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_stat(input bit busy);
        return {busy, 1'b0, beos, 1'b0, di, REV, 1'b0,
                bq.size() == FD, bq.size() == 0, 1'b0};
    endfunction

    function automatic bit exp_irq();
        return (beos && bmode[1]) || (beoc && bmode[0]);
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
        if (a == 3'd0) begin
            bgate = d[12]; bext = d[15]; barmed = 0;
            bstart = d[3:0]; blast = d[11:8]; bpos = bstart;
        end else if (a == 3'd2) bl[d[11:8]] = {d[7], d[5:4], d[3:0]};
        else if (a == 3'd3) begin bmode = d[7:0]; bscan = d[3]; end
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 0;
        if (a == 3'd1) begin beos = 0; beoc = 0; end
        if (a == 3'd4) bq.delete();
        if (a == 3'd0 && bq.size() > 0) lastv = bq.pop_front();
    endtask

    task automatic conv(input logic [15:0] smp, input bit chk_busy);
        bit acc;
        logic [15:0] st;
        acc = bgate && (!bext || barmed);
        @(negedge clk); conv_pulse = 1;
        @(negedge clk); conv_pulse = 0;
        chk(conv_start == acc, "R4 accept", conv_start, acc);
        if (acc) begin
            chk({fe_unipolar, fe_gain, fe_chan} == bl[bpos], "R1 entry",
                {fe_unipolar, fe_gain, fe_chan}, bl[bpos]);
            if (chk_busy) begin
                bus_rd(3'd1, st);
                chk(st == exp_stat(1), "R9 busy", st, exp_stat(1));
            end
        end
        @(negedge clk); adc_done = 1; adc_data = smp;
        @(negedge clk); adc_done = 0;
        if (acc) begin
            if (bq.size() < FD) bq.push_back(smp);
            beoc = 1;
            if (bscan) begin
                if (bpos == blast) begin beos = 1; bpos = bstart; end
                else bpos = (bpos + 1) % 16;
            end
        end
        chk(irq == exp_irq(), "R10 irq", irq, exp_irq());
    endtask

    task automatic drain(input string req);
        logic [15:0] v, e;
        while (bq.size() > 0) begin
            e = bq[0];
            bus_rd(3'd0, v);
            chk(v == e, req, v, e);
        end
    endtask

    task automatic chk_stat(input string req);
        logic [15:0] st, e;
        e = exp_stat(0);
        bus_rd(3'd1, st);
        chk(st == e, req, st, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog R1 actual=0 expected=1");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int seed;
        seed = $urandom(1234);
        for (int i = 0; i < 16; i++) bl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state, R11 fields
        chk_stat("R11 reset status");
        chk(irq == 0 && gates == 0, "R10 reset irq", irq, 0);

        // R1 random list
        for (int i = 0; i < 16; i++) begin
            v = $urandom;
            bus_wr(3'd2, {4'h0, 4'(i), v[7], 1'b0, v[5:4], v[3:0]});
        end
        // R2 scan window 1..3 with eos irq
        bus_wr(3'd3, 16'h000A);
        bus_wr(3'd0, 16'h1301);
        conv(16'h1111, 1);
        for (int i = 0; i < 7; i++) conv(16'($urandom), 0);
        chk_stat("R2 eos latched");
        chk(irq == 0, "R10 cleared by status", irq, 0);
        drain("R6 order");

        // R6 overflow while wrapping
        for (int i = 0; i < FD + 3; i++) conv(16'($urandom), 0);
        chk_stat("R6 full");
        drain("R6 drop on full");
        // R7 empty read
        bus_rd(3'd0, v); chk(v == lastv, "R7 empty read", v, lastv);
        bus_rd(3'd0, v); chk(v == lastv, "R7 empty read again", v, lastv);
        chk_stat("R7 still empty");
        conv(16'hBEEF, 0);
        drain("R7 next sample");

        // R8 flush
        for (int i = 0; i < 3; i++) conv(16'($urandom), 0);
        bus_rd(3'd4, v);
        chk_stat("R8 flushed");
        conv(16'h0F0F, 0);
        drain("R8 after flush");

        // R3 scan off, eoc irq only
        bus_wr(3'd3, 16'h0001);
        bus_wr(3'd0, 16'h1705);
        for (int i = 0; i < 5; i++) conv(16'($urandom), 0);
        chk_stat("R3 no eos");
        drain("R3 samples");

        // R4 gate off and external start
        bus_wr(3'd3, 16'h000B);
        bus_wr(3'd0, 16'h0200);
        conv(16'h1234, 0);
        chk_stat("R4 gate off nothing pushed");
        bus_wr(3'd0, 16'h9200);
        conv(16'h2345, 0);
        chk_stat("R4 ext not armed");
        @(negedge clk); ext_trig = 1; barmed = 1;
        @(negedge clk); ext_trig = 0;
        for (int i = 0; i < 4; i++) conv(16'($urandom), 0);
        drain("R4 ext armed");

        // R5 control write mid-scan: position reload and zero stop
        bus_wr(3'd0, 16'h1F00);
        for (int i = 0; i < 5; i++) conv(16'($urandom), 0);
        bus_wr(3'd0, 16'h1F02);
        conv(16'h5555, 0);
        bus_wr(3'd0, 16'h0000);
        chk(gates == 0, "R5 gates low", gates, 0);
        conv(16'h6666, 0);
        chk_stat("R5 stopped");
        drain("R5 samples");

        // random mixed run
        bus_wr(3'd0, {4'h1, 4'($urandom_range(15, 8)), 4'h0, 4'($urandom_range(7, 0))});
        for (int i = 0; i < 40; i++) begin
            conv(16'($urandom), 0);
            if ($urandom_range(3, 0) == 0) chk_stat("R2 random status");
            if ($urandom_range(4, 0) == 0) drain("R6 random order");
        end
        drain("R6 final");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule